// File: doc/BRIEF.md
# Cartridge Bus Block Mover

This block copies byte blocks between main memory (DRAM) and a cartridge address space, in either direction. Software writes a DRAM address and a cartridge address into the block. It then writes one of two length registers. The one it picks sets the direction, and the write starts the transfer. The cartridge address is decoded into a battery-backed save RAM window, a ROM window, and regions that are accepted but carry no data.

ROM transfers have their length clipped so that they stop at the end of the ROM and never write past the DRAM ceiling. A ROM request whose start lies beyond either limit completes with error status and moves nothing. Every accepted request ends by setting sticky status bits and raising a level interrupt after a delay. The delay is fixed for non-ROM requests and proportional to length for ROM requests. Software clears the interrupt with a write to the status register.

Top module: `cart_dma`

## Requirements
- R1: The byte count of a request is the low 24 bits of the value written to the length register plus one. The upper 8 bits are ignored.
- R2: Writing select 2 (toward cartridge) with a cartridge address in [0x08000000, 0x08010000) copies the bytes at DRAM address+i into save RAM at offset (cartridge address − 0x08000000)+i. The save RAM port address is the low 15 bits of that offset.
- R3: Writing select 3 (toward DRAM) with a cartridge address in the save RAM window copies save RAM at ((cartridge address − 0x08000000) masked to 16 bits)+i into DRAM at DRAM address+i.
- R4: Some requests move no data: toward DRAM with a cartridge address below 0x10000000 but outside the save window (0x06000000–0x07FFFFFF included), toward DRAM at or above 0x1FC00000, and toward cartridge outside the save window. They still complete with status 2'b01 and an interrupt after the fixed 4096-cycle delay.
- R5: Toward DRAM, a cartridge address in [0x10000000, 0x1FC00000) reads ROM at offset (cartridge address − 0x10000000) masked to 26 bits, i.e. cartridge address bits 25:0, plus i. It writes DRAM at DRAM address+i and completes with status 2'b11.
- R6: For a ROM request, the count N is first cut to ROM_SIZE − offset if offset+N exceeds ROM_SIZE (4096 by default). It is then cut to 0x7FFFFF − DRAM address if DRAM address+N exceeds 0x7FFFFF.
- R7: A ROM request with offset greater than ROM_SIZE, or with DRAM address greater than 0x7FFFFF, moves no data. It still completes with status 2'b11 and an interrupt.
- R8: The completion delay D is (clipped count)/8 for a valid ROM request and (requested count)/8 for a ROM error. It is 4096 for all other requests. irq_o rises between D+N and D+N+4 clock cycles after the starting write, where N is the number of bytes moved.
- R9: busy_o is high from an accepted start until the interrupt rises. Length register writes while busy are ignored, and address register writes made while busy do not affect the running transfer.
- R10: Status bit 0 means a request completed and bit 1 means it was a ROM-window request. Both bits are sticky, like irq_o. A write to select 4 with data bit 1 set clears irq_o and the status bits.
- R11: After reset busy_o, irq_o and status_o are zero and no memory strobe is active. No strobe is active while idle.
- R12: The mover copies one byte per cycle. Each destination write carries the source data read in the previous cycle (one-cycle read latency), and only one destination is written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select: 0 DRAM addr, 1 cart addr, 2 length toward cart, 3 length toward DRAM, 4 status clear |
| cfg_wdata_i | input | 32 | Register write data |
| busy_o | output | 1 | Request in progress |
| status_o | output | 2 | Sticky completion status |
| irq_o | output | 1 | Completion interrupt, level |
| dram_addr_o | output | 24 | DRAM byte address |
| dram_re_o | output | 1 | DRAM read enable |
| dram_we_o | output | 1 | DRAM write enable |
| dram_wdata_o | output | 8 | DRAM write data |
| dram_rdata_i | input | 8 | DRAM read data, one cycle after read enable |
| sram_addr_o | output | 15 | Save RAM byte address |
| sram_re_o | output | 1 | Save RAM read enable |
| sram_we_o | output | 1 | Save RAM write enable |
| sram_wdata_o | output | 8 | Save RAM write data |
| sram_rdata_i | input | 8 | Save RAM read data, one cycle latency |
| rom_addr_o | output | 26 | ROM byte offset |
| rom_re_o | output | 1 | ROM read enable |
| rom_rdata_i | input | 8 | ROM read data, one cycle latency |

## Verification
Some properties are checked on every cycle:
- ROM reads stay below the ROM size and ROM-sourced DRAM writes stay below the DRAM ceiling.
- Each destination write follows a read one cycle earlier, and at most one destination is written.
- Memory strobes are silent when idle, and the delay timer is never reloaded while counting.
- The interrupt rises only out of the wait phase, with status bit 0 set.

The other behaviours need the bench's scenarios. These are the window decode and the clipped byte counts, the exact bytes landing in each memory, and the status codes. They also include the delay window and the starts dropped while busy.

// File: rtl/cart_dma_pkg.sv
package cart_dma_pkg;
  localparam int LEN_W = 24;
  localparam int NB_W  = LEN_W + 1;
  localparam int OFF_W = 26;
  localparam int DLY_W = 24;

  localparam logic [31:0] SAVE_BASE = 32'h0800_0000;
  localparam logic [31:0] SAVE_END  = 32'h0801_0000;
  localparam logic [31:0] ROM_BASE  = 32'h1000_0000;
  localparam logic [31:0] BOOT_BASE = 32'h1FC0_0000;

  typedef enum logic [1:0] {
    MV_NONE, MV_DRAM_TO_SRAM, MV_SRAM_TO_DRAM, MV_ROM_TO_DRAM
  } mv_mode_e;

  typedef struct packed {
    mv_mode_e          mode;
    logic [NB_W-1:0]   nbytes;
    logic [OFF_W-1:0]  cart_off;
    logic [1:0]        stat;
    logic [DLY_W-1:0]  delay;
  } xfer_plan_t;
endpackage

// File: rtl/cart_dma_decode.sv
module cart_dma_decode
  import cart_dma_pkg::*;
#(
  parameter int          DRAM_AW     = 24,
  parameter logic [31:0] ROM_SIZE    = 32'h0000_1000,
  parameter logic [31:0] DRAM_TOP    = 32'h007F_FFFF,
  parameter logic [31:0] FIXED_DELAY = 32'h0000_1000
) (
  input  logic               to_dram_i,
  input  logic [31:0]        cart_i,
  input  logic [DRAM_AW-1:0] dram_i,
  input  logic [LEN_W-1:0]   len_field_i,
  output xfer_plan_t         plan_o
);
  logic [31:0] n32, d32, off32, l1, l2;
  logic [15:0] save_off;
  logic        in_save, rom_err;

  always_comb begin
    n32      = 32'(len_field_i) + 32'd1;
    d32      = 32'(dram_i);
    off32    = 32'(cart_i[OFF_W-1:0]);
    save_off = cart_i[15:0] - SAVE_BASE[15:0];
    in_save  = (cart_i >= SAVE_BASE) && (cart_i < SAVE_END);
    rom_err  = (off32 > ROM_SIZE) || (d32 > DRAM_TOP);
    l1       = ((off32 + n32) > ROM_SIZE) ? (ROM_SIZE - off32) : n32;
    l2       = ((d32 + l1) > DRAM_TOP) ? (DRAM_TOP - d32) : l1;

    plan_o          = '0;
    plan_o.mode     = MV_NONE;
    plan_o.stat     = 2'b01;
    plan_o.delay    = DLY_W'(FIXED_DELAY);
    if (!to_dram_i) begin
      if (in_save) begin
        plan_o.mode     = MV_DRAM_TO_SRAM;
        plan_o.nbytes   = NB_W'(n32);
        plan_o.cart_off = OFF_W'(save_off);
      end
    end else if (cart_i < ROM_BASE) begin
      if (in_save) begin
        plan_o.mode     = MV_SRAM_TO_DRAM;
        plan_o.nbytes   = NB_W'(n32);
        plan_o.cart_off = OFF_W'(save_off);
      end
    end else if (cart_i < BOOT_BASE) begin
      plan_o.stat = 2'b11;
      if (rom_err) begin
        plan_o.delay = DLY_W'(n32 >> 3);
      end else begin
        plan_o.mode     = MV_ROM_TO_DRAM;
        plan_o.nbytes   = NB_W'(l2);
        plan_o.cart_off = cart_i[OFF_W-1:0];
        plan_o.delay    = DLY_W'(l2 >> 3);
      end
    end
  end
endmodule

// File: rtl/cart_dma_mover.sv
module cart_dma_mover
  import cart_dma_pkg::*;
#(
  parameter int          DRAM_AW  = 24,
  parameter int          SRAM_AW  = 15,
  parameter logic [31:0] ROM_SIZE = 32'h0000_1000,
  parameter logic [31:0] DRAM_TOP = 32'h007F_FFFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  mv_mode_e           mode_i,
  input  logic [NB_W-1:0]    nbytes_i,
  input  logic [DRAM_AW-1:0] dram_base_i,
  input  logic [OFF_W-1:0]   cart_base_i,
  output logic               done_o,
  output logic [DRAM_AW-1:0] dram_addr_o,
  output logic               dram_re_o,
  output logic               dram_we_o,
  output logic [7:0]         dram_wdata_o,
  input  logic [7:0]         dram_rdata_i,
  output logic [SRAM_AW-1:0] sram_addr_o,
  output logic               sram_re_o,
  output logic               sram_we_o,
  output logic [7:0]         sram_wdata_o,
  input  logic [7:0]         sram_rdata_i,
  output logic [OFF_W-1:0]   rom_addr_o,
  output logic               rom_re_o,
  input  logic [7:0]         rom_rdata_i
);
  mv_mode_e           mode_q;
  logic [NB_W-1:0]    n_q, rd_cnt_q, pidx_q;
  logic [DRAM_AW-1:0] dbase_q;
  logic [OFF_W-1:0]   cbase_q;
  logic               active_q, pv_q, rd_go;
  logic [DRAM_AW-1:0] d_rd, d_wr;
  logic [OFF_W-1:0]   c_rd, c_wr;

  assign rd_go  = active_q && (rd_cnt_q != n_q);
  assign done_o = active_q && (rd_cnt_q == n_q) && !pv_q;
  assign d_rd   = DRAM_AW'(32'(dbase_q) + 32'(rd_cnt_q));
  assign d_wr   = DRAM_AW'(32'(dbase_q) + 32'(pidx_q));
  assign c_rd   = OFF_W'(32'(cbase_q) + 32'(rd_cnt_q));
  assign c_wr   = OFF_W'(32'(cbase_q) + 32'(pidx_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MV_NONE;
      n_q      <= '0;
      rd_cnt_q <= '0;
      pidx_q   <= '0;
      dbase_q  <= '0;
      cbase_q  <= '0;
      active_q <= 1'b0;
      pv_q     <= 1'b0;
    end else if (start_i) begin
      mode_q   <= mode_i;
      n_q      <= (mode_i == MV_NONE) ? '0 : nbytes_i;
      dbase_q  <= dram_base_i;
      cbase_q  <= cart_base_i;
      rd_cnt_q <= '0;
      pv_q     <= 1'b0;
      active_q <= 1'b1;
    end else if (active_q) begin
      pv_q   <= rd_go;
      pidx_q <= rd_cnt_q;
      if (rd_go) rd_cnt_q <= rd_cnt_q + 1'b1;
      if (done_o) active_q <= 1'b0;
    end
  end

  always_comb begin
    dram_addr_o  = d_wr;
    dram_re_o    = 1'b0;
    dram_we_o    = 1'b0;
    dram_wdata_o = rom_rdata_i;
    sram_addr_o  = SRAM_AW'(c_wr);
    sram_re_o    = 1'b0;
    sram_we_o    = 1'b0;
    sram_wdata_o = dram_rdata_i;
    rom_addr_o   = c_rd;
    rom_re_o     = 1'b0;
    unique case (mode_q)
      MV_DRAM_TO_SRAM: begin
        dram_addr_o = d_rd;
        dram_re_o   = rd_go;
        sram_we_o   = pv_q;
      end
      MV_SRAM_TO_DRAM: begin
        sram_addr_o  = SRAM_AW'(c_rd);
        sram_re_o    = rd_go;
        dram_we_o    = pv_q;
        dram_wdata_o = sram_rdata_i;
      end
      MV_ROM_TO_DRAM: begin
        rom_re_o  = rd_go;
        dram_we_o = pv_q;
      end
      default: ;
    endcase
  end

  // R12: single destination per cycle, write trails a read by one cycle
  a_r12_one_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dram_we_o, sram_we_o}));
  a_r12_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_we_o || sram_we_o) |-> $past(dram_re_o || sram_re_o || rom_re_o));
  // R6: clipped ROM transfers stay inside both limits
  a_r6_rom_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_re_o |-> (32'(rom_addr_o) < ROM_SIZE));
  a_r6_dram_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_we_o && mode_q == MV_ROM_TO_DRAM) |-> (32'(dram_addr_o) < DRAM_TOP));
endmodule

// File: rtl/cart_dma_timer.sv
module cart_dma_timer
  import cart_dma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             fire_o
);
  logic             armed_q;
  logic [DLY_W-1:0] cnt_q;

  assign fire_o = armed_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load_i) begin
      armed_q <= 1'b1;
      cnt_q   <= delay_i;
    end else if (armed_q) begin
      if (fire_o) armed_q <= 1'b0;
      else        cnt_q   <= cnt_q - 1'b1;
    end
  end

  // R8: the countdown is never restarted while running
  a_r8_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !armed_q);
endmodule

// File: rtl/cart_dma.sv
module cart_dma
  import cart_dma_pkg::*;
#(
  parameter int          DRAM_AW     = 24,
  parameter int          SRAM_AW     = 15,
  parameter logic [31:0] ROM_SIZE    = 32'h0000_1000,
  parameter logic [31:0] DRAM_TOP    = 32'h007F_FFFF,
  parameter logic [31:0] FIXED_DELAY = 32'h0000_1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [2:0]         cfg_sel_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic               busy_o,
  output logic [1:0]         status_o,
  output logic               irq_o,
  output logic [DRAM_AW-1:0] dram_addr_o,
  output logic               dram_re_o,
  output logic               dram_we_o,
  output logic [7:0]         dram_wdata_o,
  input  logic [7:0]         dram_rdata_i,
  output logic [SRAM_AW-1:0] sram_addr_o,
  output logic               sram_re_o,
  output logic               sram_we_o,
  output logic [7:0]         sram_wdata_o,
  input  logic [7:0]         sram_rdata_i,
  output logic [OFF_W-1:0]   rom_addr_o,
  output logic               rom_re_o,
  input  logic [7:0]         rom_rdata_i
);
  localparam logic [2:0] SEL_DRAM = 3'd0, SEL_CART = 3'd1, SEL_TO_CART = 3'd2,
                         SEL_TO_DRAM = 3'd3, SEL_STAT = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_MOVE, ST_WAIT} st_e;

  st_e                state_q;
  logic [DRAM_AW-1:0] dram_q;
  logic [31:0]        cart_q;
  logic [1:0]         pend_q, status_q;
  logic [DLY_W-1:0]   dly_q;
  logic               irq_q, start, mv_done, fire, clr;
  xfer_plan_t         plan;

  assign start  = cfg_we_i && state_q == ST_IDLE &&
                  (cfg_sel_i == SEL_TO_CART || cfg_sel_i == SEL_TO_DRAM);
  assign clr    = cfg_we_i && cfg_sel_i == SEL_STAT && cfg_wdata_i[1];
  assign busy_o = state_q != ST_IDLE;
  assign status_o = status_q;
  assign irq_o    = irq_q;

  cart_dma_decode #(
    .DRAM_AW(DRAM_AW), .ROM_SIZE(ROM_SIZE), .DRAM_TOP(DRAM_TOP), .FIXED_DELAY(FIXED_DELAY)
  ) u_dec (
    .to_dram_i  (cfg_sel_i == SEL_TO_DRAM),
    .cart_i     (cart_q),
    .dram_i     (dram_q),
    .len_field_i(cfg_wdata_i[LEN_W-1:0]),
    .plan_o     (plan)
  );

  cart_dma_mover #(
    .DRAM_AW(DRAM_AW), .SRAM_AW(SRAM_AW), .ROM_SIZE(ROM_SIZE), .DRAM_TOP(DRAM_TOP)
  ) u_mv (
    .clk_i, .rst_ni,
    .start_i    (start),
    .mode_i     (plan.mode),
    .nbytes_i   (plan.nbytes),
    .dram_base_i(dram_q),
    .cart_base_i(plan.cart_off),
    .done_o     (mv_done),
    .dram_addr_o, .dram_re_o, .dram_we_o, .dram_wdata_o, .dram_rdata_i,
    .sram_addr_o, .sram_re_o, .sram_we_o, .sram_wdata_o, .sram_rdata_i,
    .rom_addr_o, .rom_re_o, .rom_rdata_i
  );

  cart_dma_timer u_tmr (
    .clk_i, .rst_ni,
    .load_i (state_q == ST_MOVE && mv_done),
    .delay_i(dly_q),
    .fire_o (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      dram_q   <= '0;
      cart_q   <= '0;
      pend_q   <= '0;
      status_q <= '0;
      dly_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (cfg_we_i && cfg_sel_i == SEL_DRAM) dram_q <= cfg_wdata_i[DRAM_AW-1:0];
      if (cfg_we_i && cfg_sel_i == SEL_CART) cart_q <= cfg_wdata_i;
      if (clr) begin
        irq_q    <= 1'b0;
        status_q <= '0;
      end
      unique case (state_q)
        ST_IDLE: if (start) begin
          pend_q  <= plan.stat;
          dly_q   <= plan.delay;
          state_q <= ST_MOVE;
        end
        ST_MOVE: if (mv_done) state_q <= ST_WAIT;
        ST_WAIT: if (fire) begin
          state_q  <= ST_IDLE;
          status_q <= status_q | pend_q;
          irq_q    <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11: memories untouched while idle
  a_r11_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(dram_re_o || dram_we_o || sram_re_o || sram_we_o || rom_re_o));
  // R8: interrupt only leaves the wait phase
  a_r8_irq_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(state_q == ST_WAIT));
  // R10: a raised interrupt always carries completion status
  a_r10_irq_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> status_o[0]);
endmodule

// File: tb/sim_cart_dma.sv
`timescale 1ns/1ps
module sim_cart_dma;
  localparam int MW = 4096;
  localparam int FIXD = 4096;
  localparam int RSZ = 4096;
  localparam int TOP = 32'h7FFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic busy, irq;
  logic [1:0] status;
  logic [23:0] dram_addr;
  logic dram_re, dram_we, sram_re, sram_we, rom_re;
  logic [7:0] dram_wdata, dram_rdata, sram_wdata, sram_rdata, rom_rdata;
  logic [14:0] sram_addr;
  logic [25:0] rom_addr;

  logic [7:0] dram_m [MW], sram_m [MW], rom_m [MW];
  logic [7:0] exp_dram [MW], exp_sram [MW];
  int checks = 0, errors = 0;
  longint cyc = 0;
  int e_mode, e_n, e_off, e_dly;
  logic [1:0] e_stat;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cart_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .busy_o(busy), .status_o(status), .irq_o(irq),
    .dram_addr_o(dram_addr), .dram_re_o(dram_re), .dram_we_o(dram_we),
    .dram_wdata_o(dram_wdata), .dram_rdata_i(dram_rdata),
    .sram_addr_o(sram_addr), .sram_re_o(sram_re), .sram_we_o(sram_we),
    .sram_wdata_o(sram_wdata), .sram_rdata_i(sram_rdata),
    .rom_addr_o(rom_addr), .rom_re_o(rom_re), .rom_rdata_i(rom_rdata)
  );

  always @(posedge clk) begin
    if (dram_we) dram_m[dram_addr[11:0]] <= dram_wdata;
    if (sram_we) sram_m[sram_addr[11:0]] <= sram_wdata;
    dram_rdata <= dram_m[dram_addr[11:0]];
    sram_rdata <= sram_m[sram_addr[11:0]];
    rom_rdata  <= rom_m[rom_addr[11:0]];
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // expected outcome from the requirements
  task automatic plan(input bit to_dram, input logic [31:0] cart, input logic [31:0] dram,
                      input logic [31:0] lf);
    int n, off, l;
    bit in_save;
    n = int'(lf & 32'hFFFFFF) + 1;                                   // R1
    in_save = cart >= 32'h0800_0000 && cart < 32'h0801_0000;
    e_mode = 0; e_n = 0; e_off = 0; e_stat = 2'b01; e_dly = FIXD;    // R4
    if (!to_dram) begin
      if (in_save) begin e_mode = 1; e_n = n; e_off = int'(cart - 32'h0800_0000); end  // R2
    end else if (cart < 32'h1000_0000) begin
      if (in_save) begin e_mode = 2; e_n = n; e_off = int'((cart - 32'h0800_0000) & 32'hFFFF); end // R3
    end else if (cart < 32'h1FC0_0000) begin
      off = int'((cart - 32'h1000_0000) & 32'h3FF_FFFF);             // R5
      e_stat = 2'b11;
      if (off > RSZ || int'(dram) > TOP) e_dly = n / 8;              // R7
      else begin
        l = n;
        if (off + l > RSZ) l = RSZ - off;                            // R6
        if (int'(dram) + l > TOP) l = TOP - int'(dram);
        e_mode = 3; e_n = l; e_off = off; e_dly = l / 8;             // R8
      end
    end
  endtask

  task automatic xfer(input bit to_dram, input logic [31:0] cart, input logic [31:0] dram,
                      input logic [31:0] lf, input bit poke, input string tag);
    longint s, t;
    int bad_d, bad_s;
    plan(to_dram, cart, dram, lf);
    for (int i = 0; i < e_n; i++) begin
      case (e_mode)
        1: exp_sram[(e_off + i) & 12'hFFF] = exp_dram[(int'(dram) + i) & 12'hFFF];
        2: exp_dram[(int'(dram) + i) & 12'hFFF] = exp_sram[(e_off + i) & 12'hFFF];
        3: exp_dram[(int'(dram) + i) & 12'hFFF] = rom_m[(e_off + i) & 12'hFFF];
        default: ;
      endcase
    end
    wr(3'd0, dram);
    wr(3'd1, cart);
    wr(to_dram ? 3'd3 : 3'd2, lf);
    s = cyc;
    if (poke) begin
      // R9: length writes while busy must be dropped
      check(busy == 1'b1, "R9 busy after start", busy, 1);
      wr(3'd0, 32'h0000_0800);
      wr(3'd1, 32'h0800_0900);
      wr(3'd2, 32'h0000_003F);
      wr(3'd3, 32'h0000_003F);
    end
    while (!irq && (cyc - s) < longint'(e_dly + e_n + 300)) @(negedge clk);
    t = cyc - s;
    check(irq == 1'b1, {"R8 irq raised ", tag}, irq, 1);
    check(t >= e_dly + e_n && t <= e_dly + e_n + 4, {"R8 R12 irq timing ", tag}, t, e_dly + e_n);
    check(busy == 1'b0, {"R9 idle at irq ", tag}, busy, 0);
    check(status == e_stat, {"R10 status ", tag}, status, e_stat);
    bad_d = 0; bad_s = 0;
    for (int i = 0; i < MW; i++) begin
      if (dram_m[i] !== exp_dram[i]) bad_d++;
      if (sram_m[i] !== exp_sram[i]) bad_s++;
    end
    check(bad_d == 0, {"R2 R3 R5 dram contents ", tag}, bad_d, 0);
    check(bad_s == 0, {"R2 R4 sram contents ", tag}, bad_s, 0);
    repeat (3) @(negedge clk);
    check(irq == 1'b1 && status == e_stat, {"R10 sticky ", tag}, {irq, status}, {1'b1, e_stat});
    wr(3'd4, 32'h0000_0001);
    check(irq == 1'b1, {"R10 clear needs bit1 ", tag}, irq, 1);
    wr(3'd4, 32'h0000_0002);
    check(irq == 1'b0 && status == 2'b00, {"R10 clear ", tag}, {irq, status}, 0);
  endtask

  initial begin
    for (int i = 0; i < MW; i++) begin
      dram_m[i] = 8'(i * 7 + 3); exp_dram[i] = dram_m[i];
      sram_m[i] = 8'(i * 13 + 91); exp_sram[i] = sram_m[i];
      rom_m[i]  = 8'(i ^ (i >> 4) ^ 8'h5A);
    end
  end

  initial begin : watchdog
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(busy == 0 && irq == 0 && status == 0, "R11 reset outputs", {busy, irq, status}, 0);
    check(!(dram_re || dram_we || sram_re || sram_we || rom_re), "R11 reset strobes", 1, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && irq == 0 && status == 0, "R11 after release", {busy, irq, status}, 0);

    xfer(1'b0, 32'h0800_0100, 32'h0000_0010, 32'hAB00_001F, 1'b0, "R1 R2 to save");
    xfer(1'b1, 32'h0800_F010, 32'h0000_0200, 32'h0000_000F, 1'b0, "R3 from save");
    xfer(1'b1, 32'h0600_1000, 32'h0000_0000, 32'h0000_003F, 1'b0, "R4 ignored");
    xfer(1'b1, 32'h1FC0_0000, 32'h0000_0000, 32'h0000_0007, 1'b0, "R4 boot region");
    xfer(1'b0, 32'h1000_0000, 32'h0000_0000, 32'h0000_0007, 1'b0, "R4 to-cart rom");
    xfer(1'b1, 32'h1000_0020, 32'h0000_0300, 32'h0000_0063, 1'b0, "R5 rom");
    xfer(1'b1, 32'h1400_0040, 32'h0000_0400, 32'h0000_001F, 1'b0, "R5 mask");
    xfer(1'b1, 32'h1000_0FF6, 32'h0000_0500, 32'h0000_003F, 1'b0, "R6 rom end");
    xfer(1'b1, 32'h1000_0100, 32'h007F_FFF0, 32'h0000_003F, 1'b0, "R6 dram top");
    xfer(1'b1, 32'h1000_1000, 32'h0000_0600, 32'h0000_003F, 1'b0, "R6 zero bytes");
    xfer(1'b1, 32'h1000_1008, 32'h0000_0000, 32'h0000_00FF, 1'b0, "R7 rom offset");
    xfer(1'b1, 32'h1000_0000, 32'h0080_0000, 32'h0000_000F, 1'b0, "R7 dram addr");
    xfer(1'b1, 32'h0800_0040, 32'h0000_0700, 32'h0000_0027, 1'b1, "R9 busy drop");

    for (int k = 0; k < 14; k++) begin
      int unsigned off, d, l;
      off = $urandom_range(RSZ + 60, 0);
      d   = $urandom_range(12'hFFF, 0);
      l   = $urandom_range(600, 0);
      xfer(1'b1, 32'h1000_0000 + off, d, l, 1'b0, "R5 R6 R7 random rom");
    end
    for (int k = 0; k < 4; k++) begin
      int unsigned off, d, l;
      off = $urandom_range(16'hFFFF, 0);
      d   = $urandom_range(12'hFFF, 0);
      l   = $urandom_range(200, 0);
      xfer(k[0], 32'h0800_0000 + off, d, l, 1'b0, "R2 R3 random save");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule